// File: doc/BRIEF.md
# Dual-Rail Jitter Attenuating Elastic Buffer

This block takes a recovered line clock that wobbles in phase, along with the two data rails clocked by it: a positive-pulse bit and a negative-pulse bit. It emits the same bit pairs on a clean clock. Each receive clock edge writes the pair into a circular store. A divided local reference drives the read side. That reference runs at eight times the line rate, so a normal output period is eight reference cycles, and the short wander on the incoming clock is soaked up by the slack in the store.

The fill level decides how the read clock is paced. A slow drift can carry the fill level close to empty or close to full. When that happens, the divider stretches each period to nine reference cycles or shrinks it to seven. The read rate then follows the input and no bit is dropped. The divider goes back to eight cycles once the fill level has returned near half full. A flag output is high while the divider is in that tracking state. A mode input chooses a deep or a shallow store. A bypass input sends the receive clock and data straight to the outputs.

Top module: `jitbuf_top`

## Requirements
- R1: After reset the k-th rising edge of out_clk (counted from zero) presents on out_pos/out_neg the pair written by the (k - D/2)-th receive clock edge after reset, where D is the active depth; the first D/2 output edges present 0/0.
- R2: small_buf = 0 selects a depth D of 128 entries and small_buf = 1 selects 32 entries; thresholds and the reset offset scale with D.
- R3: While the computed fill stays between D/16 and D - D/16, every out_clk period is 8 ref_clk cycles with 4 cycles high, and limit stays low.
- R4: When the fill reaches D - D/16 or more at a period boundary, the following periods last 7 ref_clk cycles with 3 high, and limit is high; data order is preserved.
- R5: When the fill is D/16 or less at a period boundary, the following periods last 9 ref_clk cycles with 4 high, and limit is high; data order is preserved.
- R6: In a tracking state the divider returns to 8-cycle periods, and limit falls, at the first period boundary where the fill lies within D/4 of D/2.
- R7: With bypass = 1, out_clk equals rx_clk, out_pos equals rx_pos and out_neg equals rx_neg.
- R8: A synchronous reset drives out_clk, out_pos, out_neg and limit to 0, and the divider restarts at 8 cycles.
- R9: Outside bypass, out_pos, out_neg and limit change only on the ref_clk edge where out_clk rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference at eight times the line rate |
| rx_clk | input | 1 | Recovered receive clock; rising edge writes a pair |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| rx_pos | input | 1 | Positive-rail data bit |
| rx_neg | input | 1 | Negative-rail data bit |
| small_buf | input | 1 | 0 = 128-entry store, 1 = 32-entry store |
| bypass | input | 1 | 1 = pass receive clock and data straight through |
| out_clk | output | 1 | Smoothed output clock |
| out_pos | output | 1 | Positive-rail output bit |
| out_neg | output | 1 | Negative-rail output bit |
| limit | output | 1 | High while the divider runs short or long periods |

## Verification
The bench drives three input regimes at both depths: a matched rate with a slow phase wander, a rate above nominal and a rate below it. Each regime runs long enough that the fill crosses a limit and comes back. A design with a threshold off by one depth step, or with the depth select ignored, would enter tracking mode much earlier or later than expected, and the bench compares that against the read count at which limit first rises. A divider that applied the wrong step, or that missed the half-full return band, would show a 7 during a slow run, a 9 during a fast one, or a limit that never falls. The bench rebuilds the bit stream it sent, offset by half the depth, so any lost or duplicated entry, wrong rail order or wrong reset offset shows up as a data mismatch.

// File: rtl/jb_pkg.sv
package jb_pkg;

   typedef enum logic [1:0] {
      DM_NORM = 2'd0,
      DM_FAST = 2'd1,
      DM_SLOW = 2'd2
   } dmode_t;

   function automatic logic [15:0] to_gray(input logic [15:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [15:0] from_gray(input logic [15:0] g);
      logic [15:0] b;
      b[15] = g[15];
      for (int i = 14; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/jb_wptr.sv
module jb_wptr #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] mask,
   input  logic [AW-1:0] start,
   output logic [AW-1:0] bin,
   output logic [AW-1:0] gray
);
   logic [AW-1:0] nxt;

   assign nxt = AW'(bin + AW'(1)) & mask;

   always_ff @(posedge clk) begin
      if (rst) begin
         bin  <= start;
         gray <= AW'(jb_pkg::to_gray(16'(start)));
      end else begin
         bin  <= nxt;
         gray <= AW'(jb_pkg::to_gray(16'(nxt)));
      end
   end
endmodule

// File: rtl/jb_store.sv
module jb_store #(
   parameter int DEPTH = 128,
   parameter int AW    = 7
) (
   input  logic          wclk,
   input  logic          rst,
   input  logic [AW-1:0] waddr,
   input  logic [1:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [1:0]    rdata
);
   logic [1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            cells[i] <= 2'b00;
         end
      end else begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/jb_sync.sv
module jb_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] rst_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) st[0] <= rst_val;
            else     st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) st[i] <= rst_val;
            else     st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/jb_rate.sv
module jb_rate import jb_pkg::*; #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic [DW-1:0] fill,
   input  logic [DW-1:0] half,
   input  logic [DW-1:0] lo_th,
   input  logic [DW-1:0] hi_th,
   input  logic [DW-1:0] band,
   output dmode_t        mode_nxt,
   output logic          limit
);
   dmode_t mode_q;
   dmode_t calc;

   always_comb begin
      calc = mode_q;
      case (mode_q)
         DM_NORM: begin
            if (fill >= hi_th)      calc = DM_FAST;
            else if (fill <= lo_th) calc = DM_SLOW;
         end
         default: begin
            if ((DW'(fill + band) >= half) && (fill <= DW'(half + band)))
               calc = DM_NORM;
         end
      endcase
   end

   assign mode_nxt = tick ? calc : mode_q;

   always_ff @(posedge clk) begin
      if (rst)       mode_q <= DM_NORM;
      else if (tick) mode_q <= calc;
   end

   assign limit = (mode_q != DM_NORM);
endmodule

// File: rtl/jb_div.sv
module jb_div import jb_pkg::*; #(
   parameter int NORM_DIV = 8,
   parameter int FAST_DIV = 7,
   parameter int SLOW_DIV = 9
) (
   input  logic   clk,
   input  logic   rst,
   input  dmode_t mode_nxt,
   output logic   tick,
   output logic   oclk
);
   localparam int CW = $clog2(SLOW_DIV + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] len;
   logic [CW-1:0] sel;

   always_comb begin
      case (mode_nxt)
         DM_FAST: sel = CW'(FAST_DIV);
         DM_SLOW: sel = CW'(SLOW_DIV);
         default: sel = CW'(NORM_DIV);
      endcase
   end

   assign tick = (cnt == CW'(len - CW'(1)));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         len  <= CW'(NORM_DIV);
         oclk <= 1'b0;
      end else if (tick) begin
         cnt  <= '0;
         len  <= sel;
         oclk <= 1'b1;
      end else begin
         cnt <= CW'(cnt + CW'(1));
         if (cnt == CW'((len >> 1) - CW'(1))) oclk <= 1'b0;
      end
   end
endmodule

// File: rtl/jitbuf_top.sv
module jitbuf_top import jb_pkg::*; #(
   parameter int DEPTH_MAX   = 128,
   parameter int DEPTH_MIN   = 32,
   parameter int NORM_DIV    = 8,
   parameter int FAST_DIV    = 7,
   parameter int SLOW_DIV    = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rx_clk,
   input  logic rst,
   input  logic rx_pos,
   input  logic rx_neg,
   input  logic small_buf,
   input  logic bypass,
   output logic out_clk,
   output logic out_pos,
   output logic out_neg,
   output logic limit
);
   localparam int AW = $clog2(DEPTH_MAX);
   localparam int DW = AW + 1;

   if ((DEPTH_MAX & (DEPTH_MAX - 1)) != 0 || (DEPTH_MIN & (DEPTH_MIN - 1)) != 0) begin : g_bad_pow2
      $error("jitbuf_top: depths must be powers of two");
   end
   if (DEPTH_MIN < 16 || DEPTH_MIN >= DEPTH_MAX || AW > 16) begin : g_bad_depth
      $error("jitbuf_top: depth range out of bounds");
   end
   if (!(FAST_DIV < NORM_DIV && NORM_DIV < SLOW_DIV) || FAST_DIV < 4) begin : g_bad_div
      $error("jitbuf_top: divide steps must satisfy FAST < NORM < SLOW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("jitbuf_top: at least two synchronizer stages needed");
   end

   logic [DW-1:0] depth, half, lo_th, hi_th, band, fill;
   logic [AW-1:0] mask, half_a;
   logic [AW-1:0] wr_bin, wr_gray, wr_gray_s, wr_bin_s, rd_ptr;
   logic [1:0]    rdata;
   logic          tick, div_clk, q_pos, q_neg;
   dmode_t        mode_nxt;

   assign depth  = small_buf ? DW'(DEPTH_MIN) : DW'(DEPTH_MAX);
   assign half   = depth >> 1;
   assign lo_th  = depth >> 4;
   assign hi_th  = DW'(depth - lo_th);
   assign band   = depth >> 2;
   assign mask   = AW'(depth - DW'(1));
   assign half_a = AW'(half);

   jb_wptr #(.AW(AW)) u_wptr (
      .clk(rx_clk), .rst(rst), .mask(mask), .start(half_a),
      .bin(wr_bin), .gray(wr_gray)
   );

   jb_store #(.DEPTH(DEPTH_MAX), .AW(AW)) u_store (
      .wclk(rx_clk), .rst(rst), .waddr(wr_bin), .wdata({rx_pos, rx_neg}),
      .raddr(rd_ptr), .rdata(rdata)
   );

   jb_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(ref_clk), .rst(rst),
      .rst_val(AW'(jb_pkg::to_gray(16'(half_a)))),
      .d(wr_gray), .q(wr_gray_s)
   );

   assign wr_bin_s = AW'(jb_pkg::from_gray(16'(wr_gray_s)));
   assign fill     = DW'(AW'(wr_bin_s - rd_ptr) & mask);

   jb_rate #(.DW(DW)) u_rate (
      .clk(ref_clk), .rst(rst), .tick(tick), .fill(fill),
      .half(half), .lo_th(lo_th), .hi_th(hi_th), .band(band),
      .mode_nxt(mode_nxt), .limit(limit)
   );

   jb_div #(.NORM_DIV(NORM_DIV), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
      .clk(ref_clk), .rst(rst), .mode_nxt(mode_nxt), .tick(tick), .oclk(div_clk)
   );

   always_ff @(posedge ref_clk) begin
      if (rst) begin
         rd_ptr <= '0;
         q_pos  <= 1'b0;
         q_neg  <= 1'b0;
      end else if (tick) begin
         rd_ptr <= AW'(rd_ptr + AW'(1)) & mask;
         q_pos  <= rdata[1];
         q_neg  <= rdata[0];
      end
   end

   assign out_clk = bypass ? rx_clk : div_clk;
   assign out_pos = bypass ? rx_pos : q_pos;
   assign out_neg = bypass ? rx_neg : q_neg;
endmodule

// File: rtl/jb_check.sv
module jb_check (
   input logic ref_clk,
   input logic rst,
   input logic bypass,
   input logic rx_clk,
   input logic out_clk,
   input logic oclk,
   input logic limit
);
   logic       oclk_d, seen, lim_mid, rise;
   logic [7:0] cyc;

   assign rise = oclk & ~oclk_d;

   always_ff @(posedge ref_clk) begin
      if (rst) begin
         oclk_d  <= 1'b0;
         seen    <= 1'b0;
         lim_mid <= 1'b0;
         cyc     <= 8'd0;
      end else begin
         oclk_d <= oclk;
         if (rise) begin
            cyc  <= 8'd1;
            seen <= 1'b1;
         end else if (cyc != 8'hFF) begin
            cyc <= cyc + 8'd1;
         end
         if (cyc == 8'd2) lim_mid <= limit;
      end
   end

   // R3: flag low means a plain eight-cycle period
   a_r3_norm_period: assert property (@(posedge ref_clk) disable iff (rst)
      (rise && seen && !lim_mid) |-> (cyc == 8'd8));

   // R4 / R5: flag high means a seven- or nine-cycle period
   a_r4_track_period: assert property (@(posedge ref_clk) disable iff (rst)
      (rise && seen && lim_mid) |-> (cyc == 8'd7 || cyc == 8'd9));

   // R9: the flag moves only together with an output clock rise
   a_r9_limit_on_rise: assert property (@(posedge ref_clk) disable iff (rst)
      (limit != $past(limit)) |-> (oclk && !$past(oclk)));

   // R7: bypass routes the receive clock to the output
   a_r7_bypass_clk: assert property (@(posedge ref_clk) disable iff (rst)
      bypass |-> (out_clk == rx_clk));

   // R8: reset leaves flag and divided clock low
   a_r8_reset_state: assert property (@(posedge ref_clk)
      rst |=> (!limit && !oclk));
endmodule

bind jitbuf_top jb_check u_chk (
   .ref_clk(ref_clk), .rst(rst), .bypass(bypass), .rx_clk(rx_clk),
   .out_clk(out_clk), .oclk(div_clk), .limit(limit)
);

// File: tb/sim_jitbuf_top.sv
module sim_jitbuf_top;
   timeunit 1ns;
   timeprecision 10ps;

   localparam int REF_PERIOD = 10;

   logic ref_clk = 1'b0;
   logic rx_clk = 1'b0, rst = 1'b1, rx_pos = 1'b0, rx_neg = 1'b0;
   logic small_buf = 1'b0, bypass = 1'b0;
   logic out_clk, out_pos, out_neg, limit;

   always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

   jitbuf_top u0 (
      .ref_clk(ref_clk), .rx_clk(rx_clk), .rst(rst), .rx_pos(rx_pos), .rx_neg(rx_neg),
      .small_buf(small_buf), .bypass(bypass), .out_clk(out_clk), .out_pos(out_pos),
      .out_neg(out_neg), .limit(limit)
   );

   int checks = 0, fails = 0;
   logic [1:0] sent [0:4095];
   int widx, dep_half;

   bit mon_en = 0, seen, lim_seen, lim_fell;
   logic prev_oc, prev_pos, prev_neg, prev_lim;
   int cyc, hi, n7, n8, n9, nbad, hibad, mism, chg_bad, ridx, first_lim;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge ref_clk) begin
      if (mon_en) begin
         if (out_clk && !prev_oc) begin
            logic [1:0] exp;
            if (seen) begin
               case (cyc)
                  7: begin n7++; if (hi != 3) hibad++; end
                  8: begin n8++; if (hi != 4) hibad++; end
                  9: begin n9++; if (hi != 4) hibad++; end
                  default: nbad++;
               endcase
            end
            seen = 1; cyc = 1; hi = 1;
            if (ridx < dep_half) exp = 2'b00;
            else if (ridx - dep_half < widx) exp = sent[ridx - dep_half];
            else exp = 2'bxx;
            if ({out_pos, out_neg} !== exp) mism++;
            ridx++;
         end else begin
            cyc++;
            if (out_clk) hi++;
            if (out_pos != prev_pos || out_neg != prev_neg || limit != prev_lim) chg_bad++;
         end
         if (limit && !lim_seen) begin lim_seen = 1; first_lim = ridx; end
         if (!limit && prev_lim) lim_fell = 1;
         prev_oc = out_clk; prev_pos = out_pos; prev_neg = out_neg; prev_lim = limit;
      end
   end

   task automatic rx_cycle(input real hp, input bit rec, input bit rel);
      rx_clk = 1'b1;
      #(hp);
      rx_clk = 1'b0;
      rx_pos = 1'($urandom);
      rx_neg = 1'($urandom);
      if (rec && widx < 4096) begin
         sent[widx] = {rx_pos, rx_neg};
         widx++;
      end
      if (rel) begin
         rst = 1'b0;
         prev_oc = out_clk; prev_pos = out_pos; prev_neg = out_neg; prev_lim = limit;
         mon_en = 1;
      end
      #(hp);
   endtask

   // pat: 0 matched rate with wander, 1 fast input, 2 slow input
   task automatic run(input bit sb, input int n, input int pat, input bit rst_chk);
      mon_en = 0; rst = 1'b1; small_buf = sb; bypass = 1'b0;
      seen = 0; lim_seen = 0; lim_fell = 0;
      cyc = 0; hi = 0; n7 = 0; n8 = 0; n9 = 0; nbad = 0; hibad = 0;
      mism = 0; chg_bad = 0; ridx = 0; first_lim = -1;
      widx = 0; dep_half = sb ? 16 : 64;
      repeat (3) rx_cycle(40.0, 0, 0);
      if (rst_chk) begin
         chk(out_clk == 1'b0, "R8", "out_clk in reset", out_clk, 0);
         chk(limit == 1'b0, "R8", "limit in reset", limit, 0);
         chk({out_pos, out_neg} == 2'b00, "R8", "data in reset", {out_pos, out_neg}, 0);
      end
      rx_cycle(40.0, 1, 1);
      for (int i = 0; i < n; i++) begin
         real hp;
         case (pat)
            1: hp = 37.5;
            2: hp = 42.5;
            default: hp = ((i / 16) % 2 == 1) ? 45.0 : 35.0;
         endcase
         rx_cycle(hp, 1, 0);
      end
      mon_en = 0;
   endtask

   initial begin
      repeat (180000) @(posedge ref_clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2;
      // matched rate, deep store
      run(1'b0, 1024, 0, 1'b1);
      chk(nbad + n7 + n9 == 0, "R3", "off-nominal periods", nbad + n7 + n9, 0);
      chk(n8 > 800, "R3", "nominal period count", n8, 801);
      chk(hibad == 0, "R3", "high-time errors", hibad, 0);
      chk(!lim_seen, "R3", "limit raised under wander", lim_seen, 0);
      chk(mism == 0, "R1", "data mismatches", mism, 0);
      chk(ridx > dep_half + 800, "R1", "reads compared", ridx, dep_half + 801);
      chk(chg_bad == 0, "R9", "changes off the rising edge", chg_bad, 0);

      // fast input, deep store
      run(1'b0, 2200, 1, 1'b0);
      chk(n7 > 0 && n9 == 0 && nbad == 0, "R4", "short periods only", n7, 1);
      chk(lim_seen, "R4", "limit raised", lim_seen, 1);
      chk(first_lim > 600, "R2", "deep store first limit read", first_lim, 601);
      chk(lim_fell, "R6", "limit returned low (fast)", lim_fell, 1);
      chk(hibad == 0, "R4", "high-time errors", hibad, 0);
      chk(mism == 0, "R4", "data mismatches", mism, 0);
      chk(chg_bad == 0, "R9", "changes off the rising edge", chg_bad, 0);

      // slow input, deep store
      run(1'b0, 2000, 2, 1'b0);
      chk(n9 > 0 && n7 == 0 && nbad == 0, "R5", "long periods only", n9, 1);
      chk(lim_fell, "R6", "limit returned low (slow)", lim_fell, 1);
      chk(hibad == 0, "R5", "high-time errors", hibad, 0);
      chk(mism == 0, "R5", "data mismatches", mism, 0);

      // shallow store
      run(1'b1, 700, 1, 1'b0);
      chk(lim_seen && first_lim < 400, "R2", "shallow store first limit read", first_lim, 399);
      chk(n7 > 0 && n9 == 0, "R2", "shallow short periods", n7, 1);
      chk(mism == 0, "R2", "shallow data mismatches (fast)", mism, 0);
      run(1'b1, 700, 2, 1'b0);
      chk(n9 > 0 && n7 == 0, "R2", "shallow long periods", n9, 1);
      chk(lim_fell, "R6", "shallow limit returned low", lim_fell, 1);
      chk(mism == 0, "R2", "shallow data mismatches (slow)", mism, 0);

      // bypass
      bypass = 1'b1;
      begin
         int bad_clk = 0, bad_dat = 0;
         for (int i = 0; i < 16; i++) begin
            rx_clk = 1'b1; rx_pos = 1'($urandom); rx_neg = 1'($urandom);
            #3;
            if (out_clk !== 1'b1) bad_clk++;
            if ({out_pos, out_neg} !== {rx_pos, rx_neg}) bad_dat++;
            #5;
            rx_clk = 1'b0; rx_pos = ~rx_pos;
            #3;
            if (out_clk !== 1'b0) bad_clk++;
            if ({out_pos, out_neg} !== {rx_pos, rx_neg}) bad_dat++;
            #5;
         end
         chk(bad_clk == 0, "R7", "bypass clock mismatches", bad_clk, 0);
         chk(bad_dat == 0, "R7", "bypass data mismatches", bad_dat, 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule